// File: doc/BRIEF.md
# Two-Channel Interval Timer with Byte-Pair Count Loading

This block is a compact interval timer with two counting channels on a byte-wide register bus. Software first writes a control word that names a channel and picks its counting mode. It then loads that channel's 16-bit count with two data writes, low byte first. The write that supplies the high byte starts the count. A fractional accumulator derives a fixed-rate count tick (1,193,180 Hz by default) from the system clock. Each channel decrements only on tick cycles.

Mode 0 is a one-shot. At terminal count the channel halts and raises a completion code in a status byte that software can read. Every other mode reloads the same interval and runs on. Each terminal count also gives a one-cycle pulse on that channel's `tc` output. A control word that the block cannot honour changes nothing and gives a one-cycle pulse on `cfg_err`.

Register map on `addr`:

| addr | write | read (with `rd_en`) |
|---|---|---|
| 0 | data byte for channel 0 | 0x00 |
| 1 | ignored | 0x00 |
| 2 | data byte for channel 2 | 0x00 |
| 3 | control word | status byte of channel 2 |

The load sequencer has two states, `LD_LOW` and `LD_HIGH`, and this one flag is shared by both channels:

- `LD_LOW` → `LD_HIGH` on any data write, which stores the low byte.
- `LD_HIGH` → `LD_LOW` on any data write, which starts the addressed channel.

Each channel has three states, `CH_IDLE`, `CH_COUNT` and `CH_DONE`:

- `CH_IDLE`/`CH_DONE` → `CH_COUNT` on a start.
- `CH_COUNT` → `CH_COUNT` on a start, which restarts the count, or on a terminal count in a periodic mode, which reloads.
- `CH_COUNT` → `CH_DONE` on a terminal count in mode 0.

Top module: `ivt_core`

## Requirements
- R1: A write at addr 3 is a control word. It is legal only when bits 7:6 are 0 (channel 0) or 2 (channel 2), bits 5:4 are 0b11, and bit 0 is 0. An illegal word changes no state, and `cfg_err` is 1 for exactly the one cycle after the write.
- R2: A legal control word sets the addressed channel's mode to bits 3:1. In mode 0 the channel stops at terminal count, and reads at addr 3 (with `rd_en`) then return 0x20 for channel 2 until the next start.
- R3: One flag shared by both channels decides the byte order. The first data write (addr 0 or 2) only stores the low byte. The next data write, at either data address, supplies the high byte and starts the channel at that address with {high, low}. Control writes do not move the flag.
- R4: Starting a channel sets its status to 0x00 in the cycle after the high-byte write, whether it was idle, counting or done.
- R5: In any mode other than 0, a channel that reaches terminal count reloads the same count and keeps counting. Each terminal count pulses `tc` (bit 0 for channel 0, bit 1 for channel 2).
- R6: Count ticks come from a fractional accumulator, TICK_HZ ticks per CLK_HZ clock cycles with no drift. A channel started with count N reaches terminal count on its N-th tick.
- R7: A loaded count of 0 lasts 65536 ticks.
- R8: After reset both channels are idle, the load flag expects a low byte, status reads 0x00, and `tc` and `cfg_err` are 0.
- R9: A `tc` pulse lasts one cycle. A mode-0 channel gives exactly one pulse per start and none while stopped.
- R10: `rdata` is 0x00 unless `rd_en` is high with addr 3. Writes to addr 1 have no effect, including on the load flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| tc | output | 2 | Terminal-count pulses, bit 0 channel 0, bit 1 channel 2 |
| cfg_err | output | 1 | One-cycle pulse after an illegal control word |

## Verification
Two functions can meet in one cycle on a channel.

- A control-word write can land on the tick that ends a periodic run. The old mode governs that terminal count and the new one the next. The bench switches a running periodic channel to mode 0 at an arbitrary phase and judges by the status reading 0x20 within one period, with the pulse train ending.
- A high-byte start can land on a terminal tick, and the start must win. The bench restarts channel 2 while it runs and judges by the status returning to 0x00 and the fresh count's length.

Control decode and the shared byte flag also meet on one write path. The bench puts an illegal control word between a low and a high byte and expects the pending count to start intact.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int N_CH  = 2;
    localparam int CNT_W = 16;

    localparam logic [1:0] A_CTRL      = 2'd3;
    localparam logic [7:0] DONE_STATUS = 8'h20;

    typedef logic [2:0] mode_t;

    typedef enum logic [0:0] {
        LD_LOW,
        LD_HIGH
    } ld_state_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_COUNT,
        CH_DONE
    } ch_state_e;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] rw;
        mode_t      mode;
        logic       bcd;
    } ctrl_word_t;

endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 1_193_180
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int AW = $clog2(CLK_HZ) + 1;
    localparam logic [AW-1:0] STEP = AW'(TICK_HZ);
    localparam logic [AW-1:0] LIM  = AW'(CLK_HZ);

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;

    always_comb begin
        sum  = acc + STEP;
        tick = (sum >= LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= tick ? (sum - LIM) : sum;
    end

    // R6: residue stays below one clock-rate unit, so no tick is lost
    p_acc_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc < LIM);

endmodule

// File: rtl/ivt_load_seq.sv
module ivt_load_seq
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [N_CH-1:0]   start,
    output logic [CNT_W-1:0]  start_cnt,
    output logic [N_CH-1:0]   mode_we,
    output mode_t             mode_val,
    output logic              cfg_err
);
    ld_state_e  state, state_n;
    logic [7:0] low_q;
    ctrl_word_t cw;
    logic       data_wr, ctrl_wr, ctrl_ok;

    always_comb begin
        cw      = wdata;
        data_wr = wr_en && !addr[0];
        ctrl_wr = wr_en && (addr == A_CTRL);
        ctrl_ok = !cw.sel[0] && (cw.rw == 2'b11) && !cw.bcd;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= LD_LOW;
            low_q   <= '0;
            cfg_err <= 1'b0;
        end else begin
            state   <= state_n;
            cfg_err <= ctrl_wr && !ctrl_ok;
            if (data_wr && state == LD_LOW) low_q <= wdata;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            LD_LOW:  if (data_wr) state_n = LD_HIGH;
            LD_HIGH: if (data_wr) state_n = LD_LOW;
            default: state_n = LD_LOW;
        endcase
    end

    // outputs
    always_comb begin
        start_cnt = {wdata, low_q};
        mode_val  = cw.mode;
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_sel
        assign start[k]   = data_wr && (state == LD_HIGH) && (addr[1] == 1'(k));
        assign mode_we[k] = ctrl_wr && ctrl_ok && (cw.sel[1] == 1'(k));
    end

    p_err_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_ok) |=> cfg_err);
    p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && !ctrl_ok) |=> !cfg_err);
    p_flag_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (state != $past(state)));
    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(state));

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             mode_we,
    input  mode_t            mode_in,
    output logic [7:0]       status,
    output logic             tc
);
    ch_state_e        state, state_n;
    logic [CNT_W-1:0] cnt, reload;
    mode_t            mode;
    logic             terminal;

    always_comb terminal = (state == CH_COUNT) && tick && (cnt == CNT_W'(1));

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CH_IDLE;
            cnt    <= '0;
            reload <= '0;
            mode   <= '0;
            tc     <= 1'b0;
        end else begin
            state <= state_n;
            tc    <= terminal && !start;
            if (mode_we) mode <= mode_in;
            if (start) begin
                cnt    <= load_cnt;
                reload <= load_cnt;
            end else if (state == CH_COUNT && tick) begin
                cnt <= terminal ? reload : cnt - CNT_W'(1);
            end
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            CH_IDLE:  if (start) state_n = CH_COUNT;
            CH_COUNT: begin
                if (start)                          state_n = CH_COUNT;
                else if (terminal && mode == '0)    state_n = CH_DONE;
            end
            CH_DONE:  if (start) state_n = CH_COUNT;
            default:  state_n = CH_IDLE;
        endcase
    end

    // outputs
    always_comb status = (state == CH_DONE) ? DONE_STATUS : 8'h00;

    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == CH_COUNT && status == 8'h00));
    p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DONE && !start) |=> (state == CH_DONE));
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DONE && $past(state == CH_DONE)) |-> !tc);
    p_idle_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE) |-> !tc);

endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 1_193_180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    output logic [N_CH-1:0] tc,
    output logic            cfg_err
);
    logic             tick;
    logic [N_CH-1:0]  start, mode_we;
    logic [CNT_W-1:0] start_cnt;
    mode_t            mode_val;
    logic [7:0]       status [N_CH];

    ivt_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ivt_load_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .start     (start),
        .start_cnt (start_cnt),
        .mode_we   (mode_we),
        .mode_val  (mode_val),
        .cfg_err   (cfg_err)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        ivt_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .start    (start[k]),
            .load_cnt (start_cnt),
            .mode_we  (mode_we[k]),
            .mode_in  (mode_val),
            .status   (status[k]),
            .tc       (tc[k])
        );
    end

    always_comb rdata = (rd_en && addr == A_CTRL) ? status[N_CH-1] : 8'h00;

    // R8: nothing pulses in the first cycle out of reset
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> (tc == '0 && !cfg_err));

endmodule

// File: tb/ivt_core_test.sv
module ivt_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] tc;
    logic       cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    int n_tc0    = 0;
    int n_tc2    = 0;
    logic [7:0] st;

    always #5 clk = ~clk;

    ivt_core #(.CLK_HZ(4), .TICK_HZ(3)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tc(tc), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        if (tc[0]) n_tc0 <= n_tc0 + 1;
        if (tc[1]) n_tc2 <= n_tc2 + 1;
    end

    // {control word, expected cfg_err}
    localparam logic [8:0] CW_TAB [10] = '{
        {8'h70, 1'b1}, {8'h30, 1'b0}, {8'h20, 1'b1}, {8'hF0, 1'b1},
        {8'hB6, 1'b0}, {8'h10, 1'b1}, {8'hB1, 1'b1}, {8'h80, 1'b1},
        {8'h34, 1'b0}, {8'hB0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_status(output logic [7:0] v);
        addr = 2'd3; rd_en = 1'b1;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    // channel 2 was just started with count n in mode 0
    task automatic oneshot(input string req, input int n);
        int total;
        total = (4 * n + 2) / 3 + 2;
        if (n > 1) cyc(n - 1);
        rd_status(st); check(req, st, 8'h00);
        cyc(total - (n > 1 ? n - 1 : 0));
        rd_status(st); check(req, st, 8'h20);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R8 reset state
        rd_status(st); check("R8", st, 8'h00);
        check("R8", tc, 2'b00);
        check("R8", cfg_err, 1'b0);

        // R1 control-word decode table
        for (int i = 0; i < 10; i++) begin
            wr(2'd3, CW_TAB[i][8:1]);
            check("R1", cfg_err, CW_TAB[i][0]);
            cyc(1);
            check("R1", cfg_err, 1'b0);
        end

        // R1 illegal word keeps mode 0 on channel 2; R2 one-shot; R9 single pulse
        wr(2'd3, 8'hA4);
        check("R1", cfg_err, 1'b1);
        wr(2'd2, 8'h04);
        wr(2'd2, 8'h00);
        n_tc2 = 0;
        rd_status(st); check("R4", st, 8'h00);
        oneshot("R2", 4);
        cyc(20);
        check("R9", n_tc2, 1);
        rd_status(st); check("R2", st, 8'h20);

        // R3 low byte alone does not start; R4 start clears status
        wr(2'd2, 8'h0A);
        rd_status(st); check("R3", st, 8'h20);
        wr(2'd2, 8'h00);
        rd_status(st); check("R4", st, 8'h00);
        oneshot("R6", 10);

        // R3 illegal control word between bytes does not disturb the flag
        wr(2'd2, 8'h06);
        wr(2'd3, 8'h70);
        check("R1", cfg_err, 1'b1);
        wr(2'd2, 8'h00);
        rd_status(st); check("R3", st, 8'h00);
        oneshot("R3", 6);

        // R3 shared flag: low via channel 0 address, high via channel 2 address
        n_tc0 = 0;
        wr(2'd0, 8'h05);
        wr(2'd2, 8'h00);
        oneshot("R3", 5);
        check("R3", n_tc0, 0);

        // R5/R6 periodic channel 2, count 3: 300 ticks in 400 cycles
        wr(2'd3, 8'hB4);
        wr(2'd2, 8'h03);
        wr(2'd2, 8'h00);
        n_tc2 = 0;
        cyc(401);
        check("R5", n_tc2, 100);
        rd_status(st); check("R5", st, 8'h00);
        // switch to mode 0 while running: stops at the next terminal
        wr(2'd3, 8'hB0);
        cyc(8);
        rd_status(st); check("R2", st, 8'h20);
        n_tc2 = 0;
        cyc(10);
        check("R9", n_tc2, 0);

        // R5 periodic channel 0, channel 2 stays quiet
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h00);
        n_tc0 = 0; n_tc2 = 0;
        cyc(401);
        check("R5", n_tc0, 100);
        check("R5", n_tc2, 0);
        wr(2'd3, 8'h30);
        cyc(8);
        n_tc0 = 0;
        cyc(20);
        check("R9", n_tc0, 0);

        // R10 read gating
        @(negedge clk);
        addr = 2'd3; rd_en = 1'b0;
        #1 check("R10", rdata, 8'h00);
        addr = 2'd0; rd_en = 1'b1;
        #1 check("R10", rdata, 8'h00);
        rd_en = 1'b0;
        rd_status(st); check("R10", st, 8'h20);

        // R10 writes to addr 1 leave the load flag alone
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h07);
        rd_status(st); check("R10", st, 8'h20);
        wr(2'd2, 8'h00);
        rd_status(st); check("R4", st, 8'h00);

        // R7 count 0 means 65536 ticks
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h00);
        oneshot("R7", 65536);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1..: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule